// File: doc/BRIEF.md
# Interrupt request and mask controller

This block keeps one request latch per interrupt level for a small microcontroller core, together with a per-level enable mask and a global enable flag. Hardware sources raise a request with a one-cycle pulse. Software reaches the same request register through a full-width write port and a matching read port. A read-modify-write that ORs in a one-hot value therefore raises a software interrupt. That interrupt then follows the same masked, prioritised path as a hardware one.

A request is eligible when its request bit and its mask bit are both set. A fixed-priority encoder selects the eligible level with the lowest number. The block signals a pending interrupt when the global flag is on and any level is eligible. When the core acknowledges a pending interrupt, the block clears the selected request bit and drops the global flag. A later return strobe restores the flag. Software can rewrite the mask at any time, for example inside a service routine so that higher levels can preempt it.

Top module: `irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `hw_set[i]` sets request bit i at the next clock edge, unless a software write to the request register occurs in that cycle. The bit then stays set until it is cleared.
- R2: When `req_wr_en` is high, the request register takes `req_wr_data` at the clock edge. Bit i of the register is level i. `req_rd_data` always shows the current register. Writing a 1 creates a request that behaves exactly like a hardware one.
- R3: A software write to the request register takes precedence over a same-cycle hardware set and over a same-cycle acknowledge clear. The written value is stored, and the competing event is lost.
- R4: Level i is eligible only when its request bit and mask bit i are both set. When `mask_wr_en` is high, the mask takes `mask_wr_data` at the clock edge, at any time. `mask_rd_data` shows the current mask.
- R5: `irq_pending` is combinational. It is high exactly when the global enable is set and at least one level is eligible.
- R6: `irq_vector` is the binary index of the lowest-numbered eligible level, and level 0 has the highest priority. It is 0 when no level is eligible.
- R7: An `ack` while `irq_pending` is high clears the request bit of the selected level and clears the global enable at the next edge. An `ack` while `irq_pending` is low changes nothing.
- R8: If the acknowledged level also receives a hardware set in the same cycle, and there is no software write, its request bit stays set.
- R9: `ei_stb` or `iret_stb` sets the global enable, and `di_stb` clears it. A `di_stb` or an accepted acknowledge in the same cycle overrides a set.
- R10: After reset, the request register, the mask and the global enable are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_set | input | 8 | Per-level hardware set pulses |
| req_wr_en | input | 1 | Software write strobe for the request register |
| req_wr_data | input | 8 | Value written into the request register |
| req_rd_data | output | 8 | Current request register |
| mask_wr_en | input | 1 | Software write strobe for the mask |
| mask_wr_data | input | 8 | Value written into the mask |
| mask_rd_data | output | 8 | Current mask |
| ei_stb | input | 1 | Enable-interrupts strobe |
| di_stb | input | 1 | Disable-interrupts strobe |
| iret_stb | input | 1 | Return-from-interrupt strobe; restores global enable |
| ack | input | 1 | Core acknowledge of the pending interrupt |
| irq_pending | output | 1 | An eligible request exists while globally enabled |
| irq_vector | output | 3 | Index of the highest-priority eligible level |
| gie | output | 1 | Global interrupt enable flag |

## Verification
The bench targets collisions in the request register. These are a software write in the same cycle as a hardware set, and a software write in the same cycle as an acknowledge. A design that gives hardware the win would keep a bit software meant to clear, and a design that applies the acknowledge clear after the write would drop a software-raised request. The bench also acknowledges a level while that level is re-pulsed, which catches a design that lets the clear win. It issues enable and disable strobes in the same cycle, which exposes a wrong precedence in the global flag.

The bench uses masks that hide the higher-priority levels so that lower levels get selected. A wrong encoder order or ignored mask then shows up as a wrong vector. Random stimulus through a reference model covers the remaining combinations. That includes acknowledges with nothing pending, which must leave all state untouched.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int unsigned IRQ_LEVELS_DEFAULT = 8;

    typedef enum logic [1:0] {
        GIE_HOLD  = 2'd0,
        GIE_SET   = 2'd1,
        GIE_CLEAR = 2'd2
    } gie_op_e;

endpackage

// File: rtl/irq_req_reg.sv
module irq_req_reg #(
    parameter int unsigned LEVELS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] hw_set,
    input  logic              wr_en,
    input  logic [LEVELS-1:0] wr_data,
    input  logic [LEVELS-1:0] ack_clr,
    output logic [LEVELS-1:0] req_q
);

    typedef struct packed {
        logic [LEVELS-1:0] req;
    } req_state_t;

    req_state_t        state_d, state_q;
    logic [LEVELS-1:0] bit_d;

    // Per level: software write first, then hardware set, then acknowledge clear.
    for (genvar i = 0; i < LEVELS; i++) begin : g_bit
        always_comb begin
            if (wr_en) begin
                bit_d[i] = wr_data[i];
            end else if (hw_set[i]) begin
                bit_d[i] = 1'b1;
            end else begin
                bit_d[i] = state_q.req[i] & ~ack_clr[i];
            end
        end
    end

    always_comb begin
        state_d     = state_q;
        state_d.req = bit_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_q = state_q.req;

    // R3: a written value lands unchanged whatever else happens that cycle
    p_sw_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (req_q == $past(wr_data)));

    // R1: every hardware pulse is visible next cycle when software stays out
    p_hw_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((req_q & $past(hw_set)) == $past(hw_set)));

    // R2: with no event at all the register holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (hw_set == '0) && (ack_clr == '0)) |=> $stable(req_q));

endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned LEVELS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr_en,
    input  logic [LEVELS-1:0] mask_wr_data,
    input  logic              ei_stb,
    input  logic              di_stb,
    input  logic              iret_stb,
    input  logic              ack_taken,
    output logic [LEVELS-1:0] mask_q,
    output logic              gie_q
);

    typedef struct packed {
        logic [LEVELS-1:0] mask;
        logic              gie;
    } en_state_t;

    en_state_t state_d, state_q;
    gie_op_e   gie_op;

    always_comb begin
        if (di_stb || ack_taken) begin
            gie_op = GIE_CLEAR;
        end else if (ei_stb || iret_stb) begin
            gie_op = GIE_SET;
        end else begin
            gie_op = GIE_HOLD;
        end
    end

    always_comb begin
        state_d = state_q;
        if (mask_wr_en) begin
            state_d.mask = mask_wr_data;
        end
        case (gie_op)
            GIE_SET:   state_d.gie = 1'b1;
            GIE_CLEAR: state_d.gie = 1'b0;
            default:   state_d.gie = state_q.gie;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mask_q = state_q.mask;
    assign gie_q  = state_q.gie;

    p_mask_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_en |=> (mask_q == $past(mask_wr_data)));

    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr_en |=> $stable(mask_q));

    p_di_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        di_stb |=> !gie_q);

    p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ei_stb || iret_stb) && !di_stb && !ack_taken) |=> gie_q);

    p_ack_drops_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_taken |=> !gie_q);

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned LEVELS = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] eligible,
    output logic              any,
    output logic [LEVELS-1:0] sel_onehot,
    output logic [IDX_W-1:0]  sel_index
);

    // blocked[i] is high when some level below i is eligible
    logic [LEVELS:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < LEVELS; i++) begin : g_chain
        assign blocked[i+1]  = blocked[i] | eligible[i];
        assign sel_onehot[i] = eligible[i] & ~blocked[i];
    end

    assign any = blocked[LEVELS];

    always_comb begin
        sel_index = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (sel_onehot[i]) begin
                sel_index = sel_index | IDX_W'(i);
            end
        end
    end

    // R6: at most one level is chosen, and it is eligible
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_onehot) && ((sel_onehot & ~eligible) == '0));

    // R6: nothing eligible sits below the chosen level
    p_lowest_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((eligible & (sel_onehot - 1'b1)) == '0));

    p_any_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ($countones(sel_onehot) == 1));

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned LEVELS = IRQ_LEVELS_DEFAULT,
    localparam int unsigned IDX_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] hw_set,
    input  logic              req_wr_en,
    input  logic [LEVELS-1:0] req_wr_data,
    output logic [LEVELS-1:0] req_rd_data,
    input  logic              mask_wr_en,
    input  logic [LEVELS-1:0] mask_wr_data,
    output logic [LEVELS-1:0] mask_rd_data,
    input  logic              ei_stb,
    input  logic              di_stb,
    input  logic              iret_stb,
    input  logic              ack,
    output logic              irq_pending,
    output logic [IDX_W-1:0]  irq_vector,
    output logic              gie
);

    logic [LEVELS-1:0] req_q;
    logic [LEVELS-1:0] mask_q;
    logic              gie_q;
    logic [LEVELS-1:0] eligible;
    logic              any_eligible;
    logic [LEVELS-1:0] sel_onehot;
    logic [IDX_W-1:0]  sel_index;
    logic              ack_taken;
    logic [LEVELS-1:0] ack_clr;

    irq_req_reg #(.LEVELS(LEVELS)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_set  (hw_set),
        .wr_en   (req_wr_en),
        .wr_data (req_wr_data),
        .ack_clr (ack_clr),
        .req_q   (req_q)
    );

    irq_enable_ctrl #(.LEVELS(LEVELS)) u_en (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_wr_en   (mask_wr_en),
        .mask_wr_data (mask_wr_data),
        .ei_stb       (ei_stb),
        .di_stb       (di_stb),
        .iret_stb     (iret_stb),
        .ack_taken    (ack_taken),
        .mask_q       (mask_q),
        .gie_q        (gie_q)
    );

    assign eligible = req_q & mask_q;

    irq_prio_enc #(.LEVELS(LEVELS), .IDX_W(IDX_W)) u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .eligible   (eligible),
        .any        (any_eligible),
        .sel_onehot (sel_onehot),
        .sel_index  (sel_index)
    );

    assign irq_pending  = gie_q & any_eligible;
    assign ack_taken    = ack & irq_pending;
    assign ack_clr      = ack_taken ? sel_onehot : '0;
    assign irq_vector   = sel_index;
    assign req_rd_data  = req_q;
    assign mask_rd_data = mask_q;
    assign gie          = gie_q;

    // R7: the served level is gone next cycle unless software or hardware refills it
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_pending && !req_wr_en) |=>
            ((req_rd_data & $past(sel_onehot & ~hw_set)) == '0));

    // R7: an acknowledge with nothing pending touches nothing
    p_ack_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_pending && !req_wr_en) |=>
            (req_rd_data == ($past(req_rd_data) | $past(hw_set))));

    // R8: a same-cycle hardware pulse on the served level survives
    p_refill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_pending && !req_wr_en) |=>
            ((req_rd_data & $past(sel_onehot & hw_set)) == $past(sel_onehot & hw_set)));

    // R5: pending implies the core is allowed to take it
    p_pending_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> (gie && ((req_rd_data & mask_rd_data) != '0)));

endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] hw_set;
    logic         req_wr_en;
    logic [N-1:0] req_wr_data;
    logic [N-1:0] req_rd_data;
    logic         mask_wr_en;
    logic [N-1:0] mask_wr_data;
    logic [N-1:0] mask_rd_data;
    logic         ei_stb, di_stb, iret_stb, ack;
    logic         irq_pending;
    logic [2:0]   irq_vector;
    logic         gie;

    irq_ctrl #(.LEVELS(N)) uut (
        .clk(clk), .rst_n(rst_n), .hw_set(hw_set),
        .req_wr_en(req_wr_en), .req_wr_data(req_wr_data), .req_rd_data(req_rd_data),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data), .mask_rd_data(mask_rd_data),
        .ei_stb(ei_stb), .di_stb(di_stb), .iret_stb(iret_stb), .ack(ack),
        .irq_pending(irq_pending), .irq_vector(irq_vector), .gie(gie)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    int m_req, m_mask, m_gie;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int lowest(input int v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic idle();
        hw_set = '0; req_wr_en = 0; req_wr_data = '0;
        mask_wr_en = 0; mask_wr_data = '0;
        ei_stb = 0; di_stb = 0; iret_stb = 0; ack = 0;
    endtask

    // Inputs are set at a falling edge; check comb outputs, clock once, check state.
    task automatic tick(input string tag);
        int elig, pend, vec, ackv, nreq, nmask, ngie;
        #1;
        elig = m_req & m_mask;
        pend = (m_gie != 0 && elig != 0) ? 1 : 0;
        vec  = lowest(elig);
        chk({tag, " R5 pending"}, int'(irq_pending), pend);
        chk({tag, " R6 vector"}, int'(irq_vector), vec);
        ackv = (ack && pend) ? 1 : 0;
        if (req_wr_en) nreq = int'(req_wr_data);
        else nreq = (m_req & ~(ackv ? (1 << vec) : 0)) | int'(hw_set);
        nmask = mask_wr_en ? int'(mask_wr_data) : m_mask;
        if (di_stb || ackv) ngie = 0;
        else if (ei_stb || iret_stb) ngie = 1;
        else ngie = m_gie;
        @(posedge clk);
        @(negedge clk);
        m_req = nreq & 'hFF; m_mask = nmask & 'hFF; m_gie = ngie;
        chk({tag, " R1 R2 R3 R7 R8 request"}, int'(req_rd_data), m_req);
        chk({tag, " R4 mask"}, int'(mask_rd_data), m_mask);
        chk({tag, " R7 R9 gie"}, int'(gie), m_gie);
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_req = 0; m_mask = 0; m_gie = 0;
        // R10: reset state
        chk("R10 request after reset", int'(req_rd_data), 0);
        chk("R10 mask after reset", int'(mask_rd_data), 0);
        chk("R10 gie after reset", int'(gie), 0);

        hw_set = 8'h20;                      tick("R1 hw pulse level 5");
        tick("R1 level 5 held");
        req_wr_en = 1; req_wr_data = req_rd_data | 8'h04; tick("R2 software OR level 2");
        mask_wr_en = 1; mask_wr_data = 8'h24; tick("R4 mask 2 and 5");
        ei_stb = 1;                          tick("R9 enable");
        ack = 1;                             tick("R7 ack level 2");
        ack = 1;                             tick("R7 ack ignored when disabled");
        iret_stb = 1;                        tick("R9 iret restores");
        mask_wr_en = 1; mask_wr_data = 8'h00; tick("R4 mask hides all");
        ack = 1;                             tick("R7 ack ignored when masked");
        hw_set = 8'h08; req_wr_en = 1; req_wr_data = 8'h01; tick("R3 write beats hw set");
        mask_wr_en = 1; mask_wr_data = 8'hFF; tick("R4 unmask all");
        ack = 1; hw_set = 8'h01;             tick("R8 ack with refill");
        ei_stb = 1; di_stb = 1;              tick("R9 di overrides ei");
        iret_stb = 1;                        tick("R9 iret");
        ack = 1; req_wr_en = 1; req_wr_data = 8'h01; tick("R3 write beats ack clear");
        mask_wr_en = 1; mask_wr_data = 8'hFE; hw_set = 8'h80; tick("R6 mask level 0");

        for (int k = 0; k < 3000; k++) begin
            hw_set      = ($urandom % 4 == 0) ? 8'(1 << ($urandom % N)) : 8'h00;
            req_wr_en   = ($urandom % 16 == 0);
            req_wr_data = 8'($urandom);
            mask_wr_en  = ($urandom % 16 == 0);
            mask_wr_data = 8'($urandom);
            ei_stb   = ($urandom % 8 == 0);
            di_stb   = ($urandom % 16 == 0);
            iret_stb = ($urandom % 8 == 0);
            ack      = ($urandom % 3 == 0);
            tick("random R1 R2 R3 R4 R5 R6 R7 R8 R9");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule